// File: doc/BRIEF.md
# Dual-Input Edge-Gated Binary Counter

This block is a small binary up counter that lives in a synchronous clock domain and watches two asynchronous count-request lines. The counter steps up by one when the first line (`rise_i`) goes from low to high while the second line (`fall_i`) is high. It also steps up by one when the second line goes from high to low while the first line is low. Either line can therefore serve as the count strobe, with the other one acting as a level enable. A rising edge on one line and a falling edge on the other are the only events that count.

Both request lines are brought into the system clock domain through multi-flop synchronisers. Edges are found by comparing each synchronised sample with the sample from the previous cycle. Each edge is qualified by the other line's synchronised level in the same cycle. An active-high clear input empties the counter at once and without a clock. Its release is synchronised, and a short recovery window then blocks the first cycle of edges. All count bits come from one register, so they change together. A single-cycle wrap flag marks the increment that takes the count from its maximum back to zero.

Top module: `gated_pair_counter`

## Requirements
- R1: While `clear_i` is high, `count_o` is 0 and `wrap_o` is 0. Raising `clear_i` clears the count with no clock edge needed. Edges on `rise_i`/`fall_i` during clear have no effect.
- R2: A low-to-high change of `rise_i` while `fall_i` is high increments `count_o` by one. The new value appears after the third rising clock edge that follows the input change.
- R3: A high-to-low change of `fall_i` while `rise_i` is low increments `count_o` by one, with the same latency as R2.
- R4: These cause no change: a rise of `rise_i` while `fall_i` is low, a fall of `fall_i` while `rise_i` is high, any fall of `rise_i`, and any rise of `fall_i`.
- R5: Steady levels on both request lines, whatever their values, leave `count_o` unchanged for any number of cycles.
- R6: `count_o` is plain binary and is updated from a single register. Between two clock edges it either stays the same or becomes its previous value plus one, modulo 2^CNT_W.
- R7: From 15, one more increment gives 0. `wrap_o` is high for exactly one clock cycle, the first cycle in which `count_o` reads 0 after the wrap, and is low at all other times.
- R8: The count advances by at most one per clock cycle. If `rise_i` rises and `fall_i` falls together, the count does not change, because each edge sees the other line's new level.
- R9: The qualifying level is the other line's synchronised level in the cycle in which the edge is seen. Both lines falling together count once (through `fall_i`, with `rise_i` now low). Both lines rising together count once (through `rise_i`, with `fall_i` now high).
- R10: Releasing `clear_i` takes effect internally after two clock edges. A qualifying edge that reaches the counter in the first cycle after that internal release is ignored. The same edge arriving one cycle later is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the request lines |
| clear_i | input | 1 | Active-high master clear: asynchronous assertion, synchronised release |
| rise_i | input | 1 | Request line that counts on its rising edge while `fall_i` is high |
| fall_i | input | 1 | Request line that counts on its falling edge while `rise_i` is low |
| count_o | output | CNT_W (4) | Current count, binary |
| wrap_o | output | 1 | One-cycle flag on the increment from all-ones to zero |

## Verification
A table drives the two request lines through every pairwise level transition, so that each kind of edge occurs with its partner line both high and low. This separates the two counting edges from the four edges that must not count. The table includes simultaneous changes on both lines: opposite-direction changes must not count (R8), and same-direction changes must count exactly once. Together these show whether the qualifier uses the partner's new level or its old one. Directed sequences then run the counter through 15 to 0 to measure the width of the wrap flag, clear the counter between clock edges, and place a qualifying edge in the first cycle after release and in the second.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

   // Qualified count events found in one system-clock cycle.
   typedef struct packed {
      logic rise_hit;   // rising edge on the rise line, partner high
      logic fall_hit;   // falling edge on the fall line, partner low
   } gpc_hits_t;

   function automatic logic gpc_any_hit(input gpc_hits_t h);
      return h.rise_hit | h.fall_hit;
   endfunction

endpackage

// File: rtl/gpc_sync.sv
// Multi-flop level synchroniser for one asynchronous line (no reset: it
// keeps tracking the input during clear so no false edge appears on release).
module gpc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("gpc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk_i) begin
         s_q <= d_i;
      end
      assign q_o = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i) begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/gpc_rst_sync.sv
// Clear conditioner: asserts asynchronously, releases after STAGES edges.
module gpc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_i,
   output logic rst_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("gpc_rst_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk_i or posedge arst_i) begin
         if (arst_i) r_q <= 1'b1;
         else        r_q <= 1'b0;
      end
      assign rst_o = r_q;
   end else begin : g_chain
      logic [STAGES-1:0] r_q;
      always_ff @(posedge clk_i or posedge arst_i) begin
         if (arst_i) r_q <= '1;
         else        r_q <= {r_q[STAGES-2:0], 1'b0};
      end
      assign rst_o = r_q[STAGES-1];
   end

endmodule

// File: rtl/gpc_edge_qual.sv
// Edge detection on the synchronised lines plus cross-qualification.
module gpc_edge_qual
   import gpc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_i,
   input  logic      rise_lvl_i,
   input  logic      fall_lvl_i,
   output gpc_hits_t hits_o
);

   logic rise_prev_q;
   logic fall_prev_q;

   // Previous samples track the lines continuously, also during clear.
   always_ff @(posedge clk_i) begin
      rise_prev_q <= rise_lvl_i;
      fall_prev_q <= fall_lvl_i;
   end

   logic rise_edge;
   logic fall_edge;

   assign rise_edge = rise_lvl_i & ~rise_prev_q;
   assign fall_edge = ~fall_lvl_i & fall_prev_q;

   // Partner level is the current synchronised sample of the same cycle.
   always_comb begin
      hits_o          = '0;
      hits_o.rise_hit = rise_edge & fall_lvl_i;
      hits_o.fall_hit = fall_edge & ~rise_lvl_i;
   end

   AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(hits_o) <= 1);  // R8

endmodule

// File: rtl/gpc_count.sv
// Binary count register, wrap flag and post-release recovery window.
module gpc_count
   import gpc_pkg::*;
#(
   parameter int CNT_W           = 4,
   parameter int RECOVERY_CYCLES = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  gpc_hits_t        hits_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam int HOLD_W = (RECOVERY_CYCLES < 1) ? 1 : $clog2(RECOVERY_CYCLES + 1);

   if (CNT_W < 1) begin : g_bad_width
      $error("gpc_count: CNT_W must be at least 1");
   end
   if (RECOVERY_CYCLES < 0) begin : g_bad_recovery
      $error("gpc_count: RECOVERY_CYCLES must not be negative");
   end

   logic hold_act;

   if (RECOVERY_CYCLES == 0) begin : g_no_hold
      assign hold_act = 1'b0;
   end else begin : g_hold
      logic [HOLD_W-1:0] hold_q;
      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i)                hold_q <= HOLD_W'(RECOVERY_CYCLES);
         else if (hold_q != '0)    hold_q <= hold_q - HOLD_W'(1);
      end
      assign hold_act = (hold_q != '0);
   end

   logic             inc;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap_q;

   assign inc = gpc_any_hit(hits_i) & ~hold_act;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q  <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= inc & (&cnt_q);
         if (inc) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = wrap_q;

   AST_RESET_CLEAR: assert property (@(negedge clk_i)
      rst_i |-> (cnt_q == '0 && !wrap_q));  // R1

   AST_STEP_OR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CNT_W'(1)));  // R6

   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      !gpc_any_hit(hits_i) |=> $stable(cnt_q));  // R5

   AST_RECOVERY_BLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
      hold_act |=> $stable(cnt_q));  // R10

   AST_WRAP_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap_q |-> (cnt_q == '0));  // R7

   AST_WRAP_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap_q |=> !wrap_q);  // R7

endmodule

// File: rtl/gated_pair_counter.sv
module gated_pair_counter
   import gpc_pkg::*;
#(
   parameter int CNT_W           = 4,
   parameter int SYNC_STAGES     = 2,
   parameter int RST_STAGES      = 2,
   parameter int RECOVERY_CYCLES = 1
) (
   input  logic             clk_i,
   input  logic             clear_i,
   input  logic             rise_i,
   input  logic             fall_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);

   if (SYNC_STAGES < 2) begin : g_sync_warn
      $error("gated_pair_counter: SYNC_STAGES below 2 gives no metastability margin");
   end

   logic      rst_int;
   logic      rise_lvl;
   logic      fall_lvl;
   gpc_hits_t hits;

   gpc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
      .clk_i  (clk_i),
      .arst_i (clear_i),
      .rst_o  (rst_int)
   );

   gpc_sync #(.STAGES(SYNC_STAGES)) u_sync_rise (
      .clk_i (clk_i),
      .d_i   (rise_i),
      .q_o   (rise_lvl)
   );

   gpc_sync #(.STAGES(SYNC_STAGES)) u_sync_fall (
      .clk_i (clk_i),
      .d_i   (fall_i),
      .q_o   (fall_lvl)
   );

   gpc_edge_qual u_qual (
      .clk_i      (clk_i),
      .rst_i      (rst_int),
      .rise_lvl_i (rise_lvl),
      .fall_lvl_i (fall_lvl),
      .hits_o     (hits)
   );

   gpc_count #(
      .CNT_W           (CNT_W),
      .RECOVERY_CYCLES (RECOVERY_CYCLES)
   ) u_count (
      .clk_i  (clk_i),
      .rst_i  (rst_int),
      .hits_i (hits),
      .cnt_o  (count_o),
      .wrap_o (wrap_o)
   );

   AST_CLEAR_PORT: assert property (@(negedge clk_i)
      clear_i |-> (count_o == '0 && !wrap_o));  // R1

endmodule

// File: tb/gated_pair_counter_test.sv
`timescale 1ns/1ps
module gated_pair_counter_test;

   logic       clk = 1'b0;
   logic       clear = 1'b1;
   logic       rise = 1'b0;
   logic       fall = 1'b0;
   logic [3:0] cnt;
   logic       wrap;

   int total = 0;
   int bad   = 0;
   int wraps = 0;

   always #2.5 clk = ~clk;

   gated_pair_counter uut (
      .clk_i   (clk),
      .clear_i (clear),
      .rise_i  (rise),
      .fall_i  (fall),
      .count_o (cnt),
      .wrap_o  (wrap)
   );

   always @(negedge clk) if (wrap === 1'b1) wraps++;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic a, input logic b);
      @(negedge clk);
      rise = a;
      fall = b;
      repeat (4) @(negedge clk);
   endtask

   function automatic string tag_name(input logic [2:0] t);
      case (t)
         3'd0:    return "R2";
         3'd1:    return "R3";
         3'd2:    return "R4";
         3'd3:    return "R8";
         default: return "R9";
      endcase
   endfunction

   // {rise, fall, requirement code, expected count}
   localparam logic [8:0] VEC [16] = '{
      {1'b0, 1'b1, 3'd2, 4'd0},   // fall line rises: R4
      {1'b1, 1'b1, 3'd0, 4'd1},   // rise edge, partner high: R2
      {1'b1, 1'b0, 3'd2, 4'd1},   // fall edge, partner high: R4
      {1'b0, 1'b0, 3'd2, 4'd1},   // rise line falls: R4
      {1'b0, 1'b1, 3'd2, 4'd1},
      {1'b0, 1'b0, 3'd1, 4'd2},   // fall edge, partner low: R3
      {1'b1, 1'b0, 3'd2, 4'd2},   // rise edge, partner low: R4
      {1'b0, 1'b0, 3'd2, 4'd2},
      {1'b0, 1'b1, 3'd2, 4'd2},
      {1'b1, 1'b0, 3'd3, 4'd2},   // opposite edges together: R8
      {1'b1, 1'b1, 3'd2, 4'd2},
      {1'b0, 1'b1, 3'd2, 4'd2},
      {1'b1, 1'b1, 3'd0, 4'd3},
      {1'b0, 1'b0, 3'd4, 4'd4},   // both fall together: R9
      {1'b1, 1'b1, 3'd4, 4'd5},   // both rise together: R9
      {1'b0, 1'b0, 3'd1, 4'd6}
   };

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (4) @(negedge clk);
      chk("R1 count in clear", int'(cnt), 0);
      chk("R1 wrap in clear", int'(wrap), 0);
      clear = 1'b0;
      repeat (4) @(negedge clk);

      // Table walk of all level transitions
      for (int i = 0; i < 16; i++) begin
         step(VEC[i][8], VEC[i][7]);
         chk(tag_name(VEC[i][6:4]), int'(cnt), int'(VEC[i][3:0]));
      end

      // R5: static levels hold
      repeat (40) @(negedge clk);
      chk("R5 steady levels", int'(cnt), 6);
      chk("R7 no wrap yet", wraps, 0);

      // R6: count up to 15 through the fall line
      for (int v = 7; v <= 15; v++) begin
         step(1'b0, 1'b1);
         step(1'b0, 1'b0);
         chk("R6 binary step", int'(cnt), v);
      end

      // R7: wrap and one-cycle flag
      step(1'b0, 1'b1);
      @(negedge clk);
      fall = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 count wraps to zero", int'(cnt), 0);
      chk("R7 wrap flag high", int'(wrap), 1);
      @(negedge clk);
      chk("R7 wrap flag one cycle", int'(wrap), 0);
      chk("R7 single wrap pulse", wraps, 1);

      // R1: asynchronous clear between clock edges
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      chk("R3 count before clear", int'(cnt), 1);
      @(negedge clk);
      #1 clear = 1'b1;
      #1 chk("R1 immediate clear", int'(cnt), 0);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      chk("R1 edges ignored in clear", int'(cnt), 0);

      // R10: edge in first cycle after release is dropped
      @(negedge clk);
      clear = 1'b0;
      rise  = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 edge in recovery ignored", int'(cnt), 0);
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      chk("R10 counting after recovery", int'(cnt), 1);

      // R10: same edge one cycle later is counted
      @(negedge clk);
      clear = 1'b1;
      rise  = 1'b0;
      fall  = 1'b1;
      repeat (4) @(negedge clk);
      clear = 1'b0;
      @(negedge clk);
      rise = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 edge after recovery counted", int'(cnt), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule